// File: doc/BRIEF.md
# Replicated Register Steering Fabric

This block holds sixteen physical copies of a single control register, all answering at one shared data address, together with a steering selector register at a second address. The copies are arranged as four groups of four instances. The selector picks one copy through a group field and an instance field. It also carries a broadcast bit that decides how writes to the shared address are applied. When the bit is set, a write goes to every copy. When it is clear, the write goes only to the selected copy.

Reads of the shared address always return exactly one copy, the one the selector points at, whatever the broadcast bit says. Each copy has a presence bit on `avail_mask`, which marks whether the unit holding it is fused off or power gated. An access aimed at a missing copy ends quietly: a read returns zero and a single-copy write is dropped, with no error indication. A broadcast write reaches only the copies that are present.

Access is through a simple request port that carries a valid, a write flag, an address and write data. A read answers with a registered response one cycle later.

Top module: `repl_steer_fabric`

## Requirements
- R1: After reset the selector reads back 0x8000_0000, which means broadcast set, group 0 and instance 0, and every copy holds zero.
- R2: The selector sits at address 0x00. The instance ID occupies bits [1:0], the group ID bits [9:8] and the broadcast bit bit 31. Written fields read back unchanged, and all other selector bits read as zero.
- R3: A write to the data address (0x04) with the broadcast bit set stores the write data in every copy whose `avail_mask` bit is 1.
- R4: A broadcast data write leaves every copy whose `avail_mask` bit is 0 unchanged.
- R5: A data write with the broadcast bit clear updates only copy number group*4+instance, and only if that copy is present. All other copies keep their values.
- R6: A single-copy data write aimed at a copy whose `avail_mask` bit is 0 changes no copy.
- R7: A data read returns copy number group*4+instance, both with the broadcast bit set and with it clear.
- R8: A data read aimed at a copy whose `avail_mask` bit is 0 returns zero.
- R9: Reads of any address other than 0x00 and 0x04 return zero, and writes to such addresses change neither the selector nor any copy.
- R10: Every read request gives `rsp_valid` high, with its data on `rsp_rdata`, in the cycle after the request. Writes and idle cycles give no response: `rsp_valid` is low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Byte address of the access |
| req_wdata | input | 32 | Write data |
| avail_mask | input | 16 | Per-copy presence, bit i for copy i |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |

## Verification
Data writes are tried in three patterns, each followed by reads of the targeted copy and of its neighbours:
- A broadcast write with all copies present separates an update of all copies from an update of one.
- A broadcast write with one copy absent shows that copies which are not present are protected.
- Single-copy writes at several group and instance pairs, including group 3, show that the copy index is built from both fields and does not leak into neighbouring copies.

Reads are made with the broadcast bit both set and clear, which distinguishes steered reads from reads that follow the write mode. Reads and writes aimed at an absent copy separate termination from normal access. An all-ones selector write exposes bits that should read as zero.

// File: rtl/repl_steer_pkg.sv
`timescale 1ns/1ps
package repl_steer_pkg;

    localparam int REG_W          = 32;
    localparam int NUM_GROUPS     = 4;
    localparam int INST_PER_GROUP = 4;
    localparam int NUM_COPIES     = NUM_GROUPS * INST_PER_GROUP;
    localparam int GRP_W          = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int INST_W         = (INST_PER_GROUP > 1) ? $clog2(INST_PER_GROUP) : 1;
    localparam int CIDX_W         = (NUM_COPIES > 1) ? $clog2(NUM_COPIES) : 1;

    // Selector field placement (software-visible layout)
    localparam int SEL_INST_LSB  = 0;
    localparam int SEL_GRP_LSB   = 8;
    localparam int SEL_MCAST_BIT = 31;

    typedef logic [REG_W-1:0]      word_t;
    typedef logic [NUM_COPIES-1:0] copy_mask_t;
    typedef logic [CIDX_W-1:0]     copy_idx_t;

    typedef struct packed {
        logic              mcast;
        logic [GRP_W-1:0]  grp;
        logic [INST_W-1:0] inst;
    } steer_sel_t;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_SEL_WR,
        ACC_SEL_RD,
        ACC_DATA_WR,
        ACC_DATA_RD,
        ACC_VOID_WR,
        ACC_VOID_RD
    } acc_kind_t;

    localparam steer_sel_t SEL_RESET = '{mcast: 1'b1, grp: '0, inst: '0};

    function automatic copy_idx_t copy_index(steer_sel_t s);
        copy_idx_t g;
        copy_idx_t i;
        g = copy_idx_t'(s.grp);
        i = copy_idx_t'(s.inst);
        return copy_idx_t'(g * copy_idx_t'(INST_PER_GROUP)) + i;
    endfunction

    function automatic steer_sel_t word_to_sel(word_t w);
        steer_sel_t s;
        s.mcast = w[SEL_MCAST_BIT];
        s.grp   = w[SEL_GRP_LSB +: GRP_W];
        s.inst  = w[SEL_INST_LSB +: INST_W];
        return s;
    endfunction

    function automatic word_t sel_to_word(steer_sel_t s);
        word_t w;
        w = '0;
        w[SEL_MCAST_BIT]             = s.mcast;
        w[SEL_GRP_LSB +: GRP_W]      = s.grp;
        w[SEL_INST_LSB +: INST_W]    = s.inst;
        return w;
    endfunction

    function automatic word_t sel_field_mask();
        word_t w;
        w = '0;
        w[SEL_MCAST_BIT]          = 1'b1;
        w[SEL_GRP_LSB +: GRP_W]   = '1;
        w[SEL_INST_LSB +: INST_W] = '1;
        return w;
    endfunction

endpackage

// File: rtl/repl_access_decode.sv
`timescale 1ns/1ps
module repl_access_decode
    import repl_steer_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SEL_OFFSET  = 'h00,
    parameter logic [ADDR_W-1:0] DATA_OFFSET = 'h04
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_kind_t         kind
);

    always_comb begin
        kind = ACC_IDLE;
        if (req_valid) begin
            if (req_addr == SEL_OFFSET) begin
                kind = req_write ? ACC_SEL_WR : ACC_SEL_RD;
            end else if (req_addr == DATA_OFFSET) begin
                kind = req_write ? ACC_DATA_WR : ACC_DATA_RD;
            end else begin
                kind = req_write ? ACC_VOID_WR : ACC_VOID_RD;
            end
        end
    end

endmodule

// File: rtl/repl_steer_sel.sv
`timescale 1ns/1ps
module repl_steer_sel
    import repl_steer_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_wr,
    input  word_t      wdata,
    input  copy_mask_t avail,
    output steer_sel_t sel,
    output copy_idx_t  tgt_idx,
    output logic       tgt_present
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SEL_RESET;
        end else if (sel_wr) begin
            sel <= word_to_sel(wdata);
        end
    end

    always_comb begin
        tgt_idx     = copy_index(sel);
        tgt_present = avail[tgt_idx];
    end

endmodule

// File: rtl/repl_copy_bank.sv
`timescale 1ns/1ps
module repl_copy_bank
    import repl_steer_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              data_wr,
    input  logic                              mcast,
    input  copy_idx_t                         tgt_idx,
    input  copy_mask_t                        avail,
    input  word_t                             wdata,
    output logic [NUM_COPIES-1:0][REG_W-1:0]  copies
);

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        logic wen;

        // A copy takes the write only when present and either broadcast
        // or explicitly selected.
        always_comb begin
            wen = data_wr && avail[c] && (mcast || (tgt_idx == copy_idx_t'(c)));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                copies[c] <= '0;
            end else if (wen) begin
                copies[c] <= wdata;
            end
        end
    end

endmodule

// File: rtl/repl_read_path.sv
`timescale 1ns/1ps
module repl_read_path
    import repl_steer_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  acc_kind_t                         kind,
    input  steer_sel_t                        sel,
    input  copy_idx_t                         tgt_idx,
    input  logic                              tgt_present,
    input  logic [NUM_COPIES-1:0][REG_W-1:0]  copies,
    output logic                              rsp_valid,
    output word_t                             rsp_rdata
);

    word_t rdata_nxt;
    logic  is_read;

    always_comb begin
        is_read = (kind == ACC_SEL_RD) || (kind == ACC_DATA_RD) || (kind == ACC_VOID_RD);
        unique case (kind)
            ACC_SEL_RD:  rdata_nxt = sel_to_word(sel);
            ACC_DATA_RD: rdata_nxt = tgt_present ? copies[tgt_idx] : '0;
            default:     rdata_nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= is_read;
            rsp_rdata <= rdata_nxt;
        end
    end

endmodule

// File: rtl/repl_steer_fabric.sv
`timescale 1ns/1ps
module repl_steer_fabric
    import repl_steer_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SEL_OFFSET  = 'h00,
    parameter logic [ADDR_W-1:0] DATA_OFFSET = 'h04
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [REG_W-1:0]      req_wdata,
    input  logic [NUM_COPIES-1:0] avail_mask,
    output logic                  rsp_valid,
    output logic [REG_W-1:0]      rsp_rdata
);

    acc_kind_t                        kind;
    steer_sel_t                       sel_q;
    copy_idx_t                        tgt_idx;
    logic                             tgt_present;
    logic [NUM_COPIES-1:0][REG_W-1:0] copy_q;

    repl_access_decode #(
        .ADDR_W      (ADDR_W),
        .SEL_OFFSET  (SEL_OFFSET),
        .DATA_OFFSET (DATA_OFFSET)
    ) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .kind      (kind)
    );

    repl_steer_sel u_sel (
        .clk         (clk),
        .rst         (rst),
        .sel_wr      (kind == ACC_SEL_WR),
        .wdata       (req_wdata),
        .avail       (avail_mask),
        .sel         (sel_q),
        .tgt_idx     (tgt_idx),
        .tgt_present (tgt_present)
    );

    repl_copy_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .data_wr (kind == ACC_DATA_WR),
        .mcast   (sel_q.mcast),
        .tgt_idx (tgt_idx),
        .avail   (avail_mask),
        .wdata   (req_wdata),
        .copies  (copy_q)
    );

    repl_read_path u_read (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .sel         (sel_q),
        .tgt_idx     (tgt_idx),
        .tgt_present (tgt_present),
        .copies      (copy_q),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata)
    );

endmodule

// File: rtl/repl_steer_fabric_chk.sv
`timescale 1ns/1ps
module repl_steer_fabric_chk
    import repl_steer_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] SEL_OFFSET  = 'h00,
    parameter logic [ADDR_W-1:0] DATA_OFFSET = 'h04
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             req_valid,
    input logic                             req_write,
    input logic [ADDR_W-1:0]                req_addr,
    input logic [REG_W-1:0]                 req_wdata,
    input logic [NUM_COPIES-1:0]            avail_mask,
    input logic                             rsp_valid,
    input logic [REG_W-1:0]                 rsp_rdata,
    input steer_sel_t                       sel,
    input logic [NUM_COPIES-1:0][REG_W-1:0] copies
);

    logic      rd_any, data_wr, data_rd, sel_rd;
    copy_idx_t chk_idx;

    always_comb begin
        rd_any  = req_valid && !req_write;
        data_wr = req_valid && req_write && (req_addr == DATA_OFFSET);
        data_rd = rd_any && (req_addr == DATA_OFFSET);
        sel_rd  = rd_any && (req_addr == SEL_OFFSET);
        chk_idx = copy_idx_t'(sel.grp) * copy_idx_t'(INST_PER_GROUP) + copy_idx_t'(sel.inst);
    end

    assert_reset_sel_R1: assert property (@(posedge clk)
        rst |=> (sel.mcast && sel.grp == '0 && sel.inst == '0));

    assert_sel_unused_zero_R2: assert property (@(posedge clk) disable iff (rst)
        sel_rd |=> ((rsp_rdata & ~sel_field_mask()) == '0));

    assert_ucast_hit_R5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !sel.mcast && avail_mask[chk_idx])
        |=> copies[$past(chk_idx)] == $past(req_wdata));

    assert_ucast_absent_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !sel.mcast && !avail_mask[chk_idx]) |=> $stable(copies));

    assert_absent_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !avail_mask[chk_idx]) |=> rsp_rdata == '0);

    assert_rsp_on_read_R10: assert property (@(posedge clk) disable iff (rst)
        rd_any |=> rsp_valid);

    assert_quiet_otherwise_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_any |=> (!rsp_valid && rsp_rdata == '0));

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy_chk
        assert_mcast_copy_R3: assert property (@(posedge clk) disable iff (rst)
            (data_wr && sel.mcast && avail_mask[c]) |=> copies[c] == $past(req_wdata));

        assert_mcast_absent_hold_R4: assert property (@(posedge clk) disable iff (rst)
            (data_wr && sel.mcast && !avail_mask[c]) |=> $stable(copies[c]));
    end

endmodule

bind repl_steer_fabric repl_steer_fabric_chk #(
    .ADDR_W      (ADDR_W),
    .SEL_OFFSET  (SEL_OFFSET),
    .DATA_OFFSET (DATA_OFFSET)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .avail_mask (avail_mask),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .sel        (sel_q),
    .copies     (copy_q)
);

// File: tb/test_repl_steer_fabric.sv
`timescale 1ns/1ps
module test_repl_steer_fabric;

    localparam logic [7:0] A_SEL  = 8'h00;
    localparam logic [7:0] A_DATA = 8'h04;
    localparam logic [7:0] A_VOID = 8'h08;

    typedef struct packed {
        logic        is_rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [15:0] avail;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b0, A_SEL,  32'h8000_0000, 16'hFFFF, 32'h0,          4'd3},  // R3 setup
        '{1'b0, A_DATA, 32'hA5A5_0001, 16'hFFFF, 32'h0,          4'd3},  // R3 broadcast
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'hA5A5_0001,  4'd7},  // R7 read with bcast set
        '{1'b0, A_SEL,  32'h0000_0102, 16'hFFFF, 32'h0,          4'd5},  // idx 6 single
        '{1'b0, A_DATA, 32'h1234_5678, 16'hFFFF, 32'h0,          4'd5},
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h1234_5678,  4'd5},  // R5 hit
        '{1'b0, A_SEL,  32'h0000_0101, 16'hFFFF, 32'h0,          4'd5},  // idx 5
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'hA5A5_0001,  4'd5},  // R5 neighbour
        '{1'b0, A_SEL,  32'h8000_0102, 16'hFFFF, 32'h0,          4'd2},
        '{1'b1, A_SEL,  32'h0,         16'hFFFF, 32'h8000_0102,  4'd2},  // R2 readback
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h1234_5678,  4'd7},  // R7 steered
        '{1'b0, A_SEL,  32'hFFFF_FFFF, 16'hFFFF, 32'h0,          4'd2},
        '{1'b1, A_SEL,  32'h0,         16'hFFFF, 32'h8000_0303,  4'd2},  // R2 unused zero
        '{1'b1, A_DATA, 32'h0,         16'h7FFF, 32'h0,          4'd8},  // R8 absent idx15
        '{1'b0, A_DATA, 32'h0BAD_F00D, 16'h7FFF, 32'h0,          4'd4},
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'hA5A5_0001,  4'd4},  // R4 absent kept
        '{1'b0, A_SEL,  32'h0000_0000, 16'hFFFF, 32'h0,          4'd3},
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h0BAD_F00D,  4'd3},  // R3 present got it
        '{1'b0, A_DATA, 32'hDEAD_BEEF, 16'hFFFE, 32'h0,          4'd6},
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h0BAD_F00D,  4'd6},  // R6 dropped
        '{1'b1, A_VOID, 32'h0,         16'hFFFF, 32'h0,          4'd9},  // R9 void read
        '{1'b0, A_VOID, 32'hFFFF_FFFF, 16'hFFFF, 32'h0,          4'd9},
        '{1'b1, A_SEL,  32'h0,         16'hFFFF, 32'h0000_0000,  4'd9},  // R9 sel untouched
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h0BAD_F00D,  4'd9},  // R9 copy untouched
        '{1'b0, A_SEL,  32'h0000_0306, 16'hFFFF, 32'h0,          4'd5},  // idx 14
        '{1'b0, A_DATA, 32'h7777_0000, 16'hFFFF, 32'h0,          4'd5},
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h7777_0000,  4'd5},  // R5 group 3
        '{1'b0, A_SEL,  32'h0000_0203, 16'hFFFF, 32'h0,          4'd5},  // idx 11
        '{1'b1, A_DATA, 32'h0,         16'hFFFF, 32'h0BAD_F00D,  4'd5}   // R5 no spill
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [15:0] avail_mask;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    repl_steer_fabric i_repl_steer_fabric (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .avail_mask (avail_mask),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [7:0] addr, input logic [31:0] data,
                          input logic [15:0] avail, output logic v, output logic [31:0] d);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = !rd;
        req_addr   = addr;
        req_wdata  = data;
        avail_mask = avail;
        @(negedge clk);
        v = rsp_valid;
        d = rsp_rdata;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic        v;
        logic [31:0] d;
        rst        = 1'b1;
        req_valid  = 1'b0;
        req_write  = 1'b0;
        req_addr   = '0;
        req_wdata  = '0;
        avail_mask = 16'hFFFF;
        apply_reset();

        // R1: reset state of selector and copies
        access(1'b1, A_SEL, 32'h0, 16'hFFFF, v, d);
        check_eq("R1 selector after reset", d, 32'h8000_0000);
        access(1'b1, A_DATA, 32'h0, 16'hFFFF, v, d);
        check_eq("R1 copy after reset", d, 32'h0);

        for (int k = 0; k < NV; k++) begin
            access(VECS[k].is_rd, VECS[k].addr, VECS[k].data, VECS[k].avail, v, d);
            if (VECS[k].is_rd) begin
                check_eq($sformatf("R%0d vector %0d data", VECS[k].req, k), d, VECS[k].exp);
                check_eq($sformatf("R10 vector %0d valid", k), {31'b0, v}, 32'h1);
            end else begin
                check_eq($sformatf("R10 vector %0d no response", k), {31'b0, v}, 32'h0);
            end
        end

        // R10: idle cycle carries no response and zero data
        @(negedge clk);
        check_eq("R10 idle valid", {31'b0, rsp_valid}, 32'h0);
        check_eq("R10 idle data", rsp_rdata, 32'h0);

        // R8: absent copy reads zero even with data stored (idx 11 holds 0BADF00D)
        access(1'b1, A_DATA, 32'h0, 16'hF7FF, v, d);
        check_eq("R8 absent idx11", d, 32'h0);

        // R1: reset in mid-run restores selector and clears copies
        apply_reset();
        access(1'b1, A_SEL, 32'h0, 16'hFFFF, v, d);
        check_eq("R1 selector after second reset", d, 32'h8000_0000);
        access(1'b1, A_DATA, 32'h0, 16'hFFFF, v, d);
        check_eq("R1 copy 0 after second reset", d, 32'h0);

        finish_run();
    end

endmodule